// File: doc/BRIEF.md
# Flash write-status bit generator

This block builds the byte returned on a read while the flash array is busy with an internal program or erase, or has an erase on hold. A command sequencer supplies the operation state: whether an internal operation is running, whether it is a program or an erase, whether an erase is suspended, and which sector the erase belongs to. It also supplies the byte being programmed. For each completed read strobe the block returns one byte, one cycle later. In that byte, bit 7 carries polling data, bit 6 carries the general activity toggle and bit 2 carries the sector-specific toggle. All other bits come from the supplied data.

Two toggle cells live inside the block. Each one advances only when a read actually reports it, so software sees alternating values across successive polling reads, however many idle cycles separate them. The answer depends on the address as well as on the operation state. A read that falls inside the suspended or erasing sector gets a different bit 2 from a read elsewhere, which lets software tell which sector is affected.

Top module: `fsg_status_gen`

## Requirements
- R1: Every cycle with `rd_stb` high produces exactly one `rd_valid` pulse, together with its `rd_data`, on the next cycle. `rd_valid` is low after any cycle without a strobe. Both outputs are zero after reset.
- R2: While `op_active` is high with `op_kind` = 2'b01 (program), a read returns `prog_data` with bit 7 inverted, bit 6 set to the activity toggle and bit 2 forced to 1.
- R3: While `op_active` is high with `op_kind` = 2'b10 (erase), a read returns bit 7 = 0 and bit 6 = the activity toggle. The remaining bits, apart from bit 2, come from `arr_data`.
- R4: The activity toggle reads 0 on the first status read after reset. It inverts after each read that reports it, during program and erase alike.
- R5: While `erase_susp` is high, a read whose sector equals `erase_sector` returns bit 7 = 1, bit 6 = 1 and bit 2 = the sector toggle. The remaining bits come from `arr_data`. This case takes priority over any running program.
- R6: During an erase, a read inside `erase_sector` returns bit 2 = the sector toggle. A read outside it returns bit 2 = 1 and leaves the sector toggle unchanged. The sector toggle reads 0 first after reset and inverts after each read that reports it.
- R7: With no operation running, and outside a suspended sector, a read returns `arr_data` unchanged. This includes the true data once a program has finished.
- R8: Neither toggle changes on cycles without a read strobe. Idle gaps between polling reads do not disturb the alternation.
- R9: A program that runs while an erase is suspended, read outside the suspended sector, reports as in R2. Its bit 6 keeps toggling.
- R10: The sector of a read is the upper `SECT_W` bits of `rd_addr`. Addresses on either side of a sector boundary fall into different sectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_active | input | 1 | Internal program or erase is running |
| op_kind | input | 2 | 2'b01 program, 2'b10 erase |
| erase_susp | input | 1 | An erase is suspended |
| erase_sector | input | SECT_W | Sector being erased or held in suspend |
| rd_stb | input | 1 | One-cycle pulse per completed read |
| rd_addr | input | ADDR_W | Read address |
| prog_data | input | 8 | True byte being programmed |
| arr_data | input | 8 | Array byte at `rd_addr` |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 8 | Read response byte |

## Verification
The bench polls with idle gaps and with back-to-back strobes. A design that stepped its toggles on the clock rather than on reads would break the expected alternation. Reads are placed just below and just at a sector boundary, and both in and out of the erasing sector. A wrong sector slice, or a sector toggle that steps on every erase read, shows up as a wrong bit 2. A program started during an erase suspend is read in both the held sector and a free one. Getting the priority backwards would report program status for the held sector.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int DATA_W = 8;
  localparam int POLL_BIT = 7;
  localparam int ACT_BIT = 6;
  localparam int SECT_BIT = 2;
  localparam logic [1:0] KIND_PROG = 2'b01;
  localparam logic [1:0] KIND_ERASE = 2'b10;

  // Overlay the three status bits on a base byte.
  function automatic logic [DATA_W-1:0] overlay(
    input logic [DATA_W-1:0] base,
    input logic poll,
    input logic act,
    input logic sect
  );
    logic [DATA_W-1:0] w;
    w = base;
    w[POLL_BIT] = poll;
    w[ACT_BIT] = act;
    w[SECT_BIT] = sect;
    return w;
  endfunction
endpackage

// File: rtl/fsg_sector_hit.sv
module fsg_sector_hit #(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 4
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SECT_W-1:0] sector,
  output logic              hit
);
  localparam int SHIFT = ADDR_W - SECT_W;

  function automatic logic [ADDR_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a >> SHIFT;
  endfunction

  assign hit = (sector_of(rd_addr) == ADDR_W'(sector));
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else if (adv) q <= ~q;
  end
endmodule

// File: rtl/fsg_status_mux.sv
module fsg_status_mux
  import fsg_pkg::*;
(
  input  logic              rd_stb,
  input  logic              op_active,
  input  logic [1:0]        op_kind,
  input  logic              erase_susp,
  input  logic              addr_hit,
  input  logic              t6_q,
  input  logic              t2_q,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [DATA_W-1:0] arr_data,
  output logic              sel_susp,
  output logic              sel_prog,
  output logic              sel_erase,
  output logic              t6_adv,
  output logic              t2_adv,
  output logic [DATA_W-1:0] nxt_data
);
  // Suspended-sector reads take priority over any running operation.
  assign sel_susp  = erase_susp && addr_hit;
  assign sel_prog  = !sel_susp && op_active && (op_kind == KIND_PROG);
  assign sel_erase = !sel_susp && op_active && (op_kind == KIND_ERASE);

  assign t6_adv = rd_stb && (sel_prog || sel_erase);
  assign t2_adv = rd_stb && (sel_susp || (sel_erase && addr_hit));

  always_comb begin
    if (sel_susp)
      nxt_data = overlay(arr_data, 1'b1, 1'b1, t2_q);
    else if (sel_prog)
      nxt_data = overlay(prog_data, ~prog_data[POLL_BIT], t6_q, 1'b1);
    else if (sel_erase)
      nxt_data = overlay(arr_data, 1'b0, t6_q, addr_hit ? t2_q : 1'b1);
    else
      nxt_data = arr_data;
  end
endmodule

// File: rtl/fsg_status_gen.sv
module fsg_status_gen
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_active,
  input  logic [1:0]        op_kind,
  input  logic              erase_susp,
  input  logic [SECT_W-1:0] erase_sector,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        prog_data,
  input  logic [7:0]        arr_data,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  localparam int NTOG = 2;

  logic              addr_hit;
  logic              sel_susp, sel_prog, sel_erase;
  logic              t6_adv, t2_adv, t6_q, t2_q;
  logic [NTOG-1:0]   tog_adv, tog_q;
  logic [DATA_W-1:0] nxt_data;

  fsg_sector_hit #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_hit (
    .rd_addr (rd_addr),
    .sector  (erase_sector),
    .hit     (addr_hit)
  );

  fsg_status_mux u_mux (
    .rd_stb     (rd_stb),
    .op_active  (op_active),
    .op_kind    (op_kind),
    .erase_susp (erase_susp),
    .addr_hit   (addr_hit),
    .t6_q       (t6_q),
    .t2_q       (t2_q),
    .prog_data  (prog_data),
    .arr_data   (arr_data),
    .sel_susp   (sel_susp),
    .sel_prog   (sel_prog),
    .sel_erase  (sel_erase),
    .t6_adv     (t6_adv),
    .t2_adv     (t2_adv),
    .nxt_data   (nxt_data)
  );

  assign tog_adv = {t2_adv, t6_adv};
  assign t6_q = tog_q[0];
  assign t2_q = tog_q[1];

  for (genvar g = 0; g < NTOG; g++) begin : g_tog
    fsg_toggle u_tog (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (tog_adv[g]),
      .q     (tog_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= nxt_data;
    end
  end
endmodule

// File: rtl/fsg_status_gen_chk.sv
module fsg_status_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic [7:0] prog_data,
  input logic [7:0] arr_data,
  input logic       sel_susp,
  input logic       sel_prog,
  input logic       sel_erase,
  input logic       addr_hit,
  input logic       t6_adv,
  input logic       t6_q,
  input logic       t2_adv,
  input logic       t2_q
);
  p_resp_follows_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);
  p_no_spurious_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid);
  p_prog_poll_inverted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && sel_prog) |=> (rd_data[7] == !$past(prog_data[7])));
  p_erase_poll_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && sel_erase) |=> !rd_data[7]);
  p_act_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
    t6_adv |=> (t6_q != $past(t6_q)));
  p_susp_act_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && sel_susp) |=> (rd_data[6] && rd_data[7]));
  p_erase_far_sect_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && sel_erase && !addr_hit) |=> rd_data[2]);
  p_sect_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
    t2_adv |=> (t2_q != $past(t2_q)));
  p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !sel_susp && !sel_prog && !sel_erase) |=> (rd_data == $past(arr_data)));
  p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(t6_q));
  p_sect_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(t2_q));
endmodule

bind fsg_status_gen fsg_status_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_stb    (rd_stb),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .prog_data (prog_data),
  .arr_data  (arr_data),
  .sel_susp  (sel_susp),
  .sel_prog  (sel_prog),
  .sel_erase (sel_erase),
  .addr_hit  (addr_hit),
  .t6_adv    (t6_adv),
  .t6_q      (t6_q),
  .t2_adv    (t2_adv),
  .t2_q      (t2_q)
);

// File: tb/fsg_status_gen_tb.sv
module fsg_status_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_active = 1'b0;
  logic [1:0]  op_kind = 2'b00;
  logic        erase_susp = 1'b0;
  logic [3:0]  erase_sector = 4'd0;
  logic        rd_stb = 1'b0;
  logic [15:0] rd_addr = 16'd0;
  logic [7:0]  prog_data = 8'd0;
  logic [7:0]  arr_data = 8'd0;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit act_m = 1'b0;
  bit sect_m = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  fsg_status_gen u_dut (
    .clk(clk), .rst_n(rst_n), .op_active(op_active), .op_kind(op_kind),
    .erase_susp(erase_susp), .erase_sector(erase_sector), .rd_stb(rd_stb),
    .rd_addr(rd_addr), .prog_data(prog_data), .arr_data(arr_data),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Reference: expected byte from the requirement text, with its own toggle state.
  function automatic logic [7:0] predict(input logic [15:0] a, input logic [7:0] arr);
    bit in_sect;
    logic [7:0] e;
    in_sect = (a[15:12] == erase_sector);
    if (erase_susp && in_sect) begin
      e = {1'b1, 1'b1, arr[5:3], sect_m, arr[1:0]};
      sect_m = !sect_m;
    end else if (op_active && op_kind == 2'b01) begin
      e = {!prog_data[7], act_m, prog_data[5:3], 1'b1, prog_data[1:0]};
      act_m = !act_m;
    end else if (op_active && op_kind == 2'b10) begin
      e = {1'b0, act_m, arr[5:3], (in_sect ? sect_m : 1'b1), arr[1:0]};
      act_m = !act_m;
      if (in_sect) sect_m = !sect_m;
    end else begin
      e = arr;
    end
    return e;
  endfunction

  task automatic do_read(input logic [15:0] a, input logic [7:0] arr, input string tag);
    rd_addr = a;
    arr_data = arr;
    rd_stb = 1'b1;
    exp_q.push_back(predict(a, arr));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pops one expected byte per response.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected response", 8'h01, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    check("R1 reset valid", {7'd0, rd_valid}, 8'h00);
    check("R1 reset data", rd_data, 8'h00);
    rst_n = 1'b1;
    idle(2);

    // R7: idle pass-through
    do_read(16'h1234, 8'hA5, "R7 idle read");
    do_read(16'h3000, 8'h3C, "R7 idle read b2b");
    idle(2);

    // R2 R4 R8: program polling with gaps
    prog_data = 8'h5A; op_kind = 2'b01; op_active = 1'b1;
    do_read(16'h2000, 8'hFF, "R2 prog read 1");
    idle(5);
    do_read(16'h2000, 8'hFF, "R4 prog read 2");
    idle(1);
    do_read(16'h2000, 8'hFF, "R8 prog read after gap");
    do_read(16'h2000, 8'hFF, "R4 prog read b2b");
    op_active = 1'b0;
    do_read(16'h2000, 8'h5A, "R7 program done true data");
    idle(2);

    // R3 R6 R10: erase of sector 3
    erase_sector = 4'd3; op_kind = 2'b10; op_active = 1'b1;
    do_read(16'h3000, 8'hFF, "R6 erase in-sector");
    do_read(16'h2FFF, 8'hFF, "R10 erase below boundary");
    do_read(16'h3FFF, 8'hFF, "R6 erase in-sector top");
    idle(3);
    do_read(16'h7000, 8'h81, "R3 erase other sector");
    do_read(16'h3004, 8'hC3, "R3 erase in-sector data");
    op_active = 1'b0;
    idle(2);

    // R5: erase suspended on sector 3
    erase_susp = 1'b1;
    do_read(16'h3010, 8'h00, "R5 suspended sector read");
    do_read(16'h3010, 8'h00, "R5 suspended sector read 2");
    do_read(16'h4010, 8'h99, "R7 free sector during suspend");
    idle(2);

    // R9: program in free sector while erase held
    prog_data = 8'h81; op_kind = 2'b01; op_active = 1'b1;
    do_read(16'h5000, 8'h00, "R9 prog during suspend");
    do_read(16'h5000, 8'h00, "R9 prog during suspend 2");
    do_read(16'h3100, 8'h24, "R5 held sector beats program");
    do_read(16'h5000, 8'h00, "R9 prog during suspend 3");
    op_active = 1'b0; erase_susp = 1'b0;
    idle(3);
    do_read(16'h3100, 8'h66, "R7 after resume idle");
    idle(4);
    check("R1 all responses seen", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule